// File: doc/BRIEF.md
# CRC-Protected Register Access Framer

This block sits on the host side of a serial link to a register target that spreads its registers over four banks, each answering at its own device address. A request names a 16-bit register address, a length of one to four bytes, a direction and, for a write, up to four data bytes. The framer checks that the address is legal and looks up the device address for the bank. It then sends the outbound frame as a stream of bytes, one per valid/ready handshake. For a read it collects the bytes that come back on a second stream and reports either completion with the read data or an error.

Two of the banks guard every transfer with an 8-bit CRC. For those banks the register byte also carries a length code. A write to them is followed by a CRC byte and a zero pad byte. A read from them expects a CRC byte after the data and checks it. The other two banks use plain frames. The block handles one request at a time. Bit-level bus signalling, start and stop conditions happen downstream of the byte stream.

Top module: `crc_reg_framer`

## Requirements
- R1: After reset `busy`, `tx_valid`, `rx_ready`, `rsp_done` and `rsp_err` are all low.
- R2: The first byte of every frame is the bank's 7-bit device address shifted left by one, with the direction in bit 0 (1 = read, 0 = write). The address high byte selects the bank: 0 → 0x4E, 1 → 0x1A, 2 → 0x64, 3 → 0x34.
- R3: A request whose address is outside 0x000–0x0FF, 0x100–0x13B, 0x200–0x21C or 0x300–0x3FF sends no byte. It raises `rsp_err` in the cycle after acceptance.
- R4: A request whose length is 0 or greater than 4 sends no byte. It raises `rsp_err` in the cycle after acceptance, on any bank.
- R5: On banks 0 and 3 the second byte is the low address byte unchanged. A write sends the data bytes next, least significant byte of `req_wdata` first, and nothing else. A read expects exactly `req_len` returned bytes with no CRC.
- R6: On banks 1 and 2 the second byte holds address bits [5:0] in bits [5:0] and length minus one in bits [7:6].
- R7: A write to bank 1 or 2 sends the address byte, the register byte and the data bytes. It then sends a CRC byte and a 0x00 pad byte. The CRC is CRC-8 with polynomial 0x07, MSB first, initial value 0x00, taken over the address byte, the register byte and the data bytes, but not the pad. `tx_last` marks only the final byte of each frame.
- R8: A read from bank 1 or 2 takes the data bytes and then one CRC byte. The CRC is computed as in R7 over the read address byte, the register byte and the returned data. On a match `rsp_done` pulses and `rsp_rdata` holds the data, with byte i in bits [8i+7:8i] and unused upper bytes zero. On a mismatch `rsp_err` pulses and `rsp_rdata` is zero.
- R9: If `rx_stop` is seen before all expected bytes of a read have arrived, `rsp_err` pulses and `rsp_rdata` is zero. A byte presented in the same cycle as `rx_stop` is not taken.
- R10: `busy` is high from the cycle after a request is accepted up to and including the single cycle in which `rsp_done` or `rsp_err` is high, and low the cycle after. `rsp_done` and `rsp_err` are never high together. A request presented while `busy` is high is ignored.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bank in high byte, register in low byte |
| req_len | input | 3 | Transfer length in bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| busy | output | 1 | A request is being processed |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Downstream accepts the outbound byte |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Final byte of the outbound frame |
| rx_valid | input | 1 | Returned byte valid |
| rx_ready | output | 1 | Framer is waiting for returned bytes |
| rx_data | input | 8 | Returned byte |
| rx_stop | input | 1 | Target ended its response |
| rsp_done | output | 1 | One-cycle pulse: request completed |
| rsp_err | output | 1 | One-cycle pulse: request failed |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |

## Verification
The hardest situation to reach from the ports is a protected read that fails only on its final byte. All data bytes have been taken and folded into the running CRC, and the last returned byte disagrees with it. A nearby variant is a response cut off by `rx_stop` after a chosen number of bytes while the downstream side is stalling at random. The bench acts as the target. It computes the correct trailing CRC itself, then either returns it, returns it with some bits flipped, or ends the response early at a random point. Random gaps on both streams move these events to different cycles relative to the state changes.

// File: rtl/crf_pkg.sv
package crf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_RECV,
    ST_DONE
  } crf_state_e;

  typedef struct packed {
    logic       ok;
    logic       use_crc;
    logic [7:0] dev_byte;
    logic [7:0] reg_byte;
  } crf_dec_t;

  // One byte of CRC-8, MSB first, no reflection, no final xor.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc_in ^ din;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/crf_decode.sv
module crf_decode
  import crf_pkg::*;
#(
  parameter int                      NUM_BANKS = 4,
  parameter int                      MAX_LEN   = 4,
  parameter int                      LEN_W     = 3,
  parameter logic [NUM_BANKS*7-1:0]  DEV_ADDRS = {7'h34, 7'h64, 7'h1A, 7'h4E},
  parameter logic [NUM_BANKS*8-1:0]  REG_LAST  = {8'hFF, 8'h1C, 8'h3B, 8'hFF},
  parameter logic [NUM_BANKS-1:0]    CRC_BANKS = 4'b0110
) (
  input  logic [15:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic             is_read,
  output crf_dec_t         dec
);

  localparam int CODE_W = $clog2(MAX_LEN);

  logic [NUM_BANKS-1:0] hit;
  logic [NUM_BANKS-1:0] in_range;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit[b]      = (addr[15:8] == 8'(b));
    assign in_range[b] = (addr[7:0] <= REG_LAST[b*8 +: 8]);
  end

  logic [6:0]        dev_sel;
  logic              crc_sel;
  logic              len_ok;
  logic [CODE_W-1:0] code;

  always_comb begin
    dev_sel = '0;
    crc_sel = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit[i]) begin
        dev_sel = DEV_ADDRS[i*7 +: 7];
        crc_sel = CRC_BANKS[i];
      end
    end
    len_ok       = (len != '0) && (len <= LEN_W'(MAX_LEN));
    code         = CODE_W'(len - 1'b1);
    dec.ok       = len_ok && (|(hit & in_range));
    dec.use_crc  = crc_sel;
    dec.dev_byte = {dev_sel, is_read};
    dec.reg_byte = crc_sel ? {code, addr[7-CODE_W:0]} : addr[7:0];
  end

endmodule

// File: rtl/crf_crc8.sv
module crf_crc8
  import crf_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc <= 8'h00;
    end else if (en) begin
      crc <= crc8_step(crc, din, POLY);
    end
  end

endmodule

// File: rtl/crc_reg_framer.sv
module crc_reg_framer
  import crf_pkg::*;
#(
  parameter int                      NUM_BANKS = 4,
  parameter int                      MAX_LEN   = 4,
  parameter int                      LEN_W     = 3,
  parameter logic [NUM_BANKS*7-1:0]  DEV_ADDRS = {7'h34, 7'h64, 7'h1A, 7'h4E},
  parameter logic [NUM_BANKS*8-1:0]  REG_LAST  = {8'hFF, 8'h1C, 8'h3B, 8'hFF},
  parameter logic [NUM_BANKS-1:0]    CRC_BANKS = 4'b0110,
  parameter logic [7:0]              CRC_POLY  = 8'h07
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [15:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MAX_LEN*8-1:0] req_wdata,
  output logic                 busy,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic                 tx_last,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  input  logic [7:0]           rx_data,
  input  logic                 rx_stop,
  output logic                 rsp_done,
  output logic                 rsp_err,
  output logic [MAX_LEN*8-1:0] rsp_rdata
);

  localparam int DATA_W = MAX_LEN * 8;
  localparam int IDX_W  = $clog2(MAX_LEN + 5);

  crf_state_e       state;
  crf_dec_t         dec;
  logic             q_read;
  logic             q_crc;
  logic [LEN_W-1:0] q_len;
  logic [DATA_W-1:0] q_wdata;
  logic [DATA_W-1:0] rx_buf;
  logic [DATA_W-1:0] rx_buf_nx;
  logic [7:0]       q_dev;
  logic [7:0]       q_reg;
  logic [IDX_W-1:0] tx_idx;
  logic [IDX_W-1:0] rx_idx;
  logic [IDX_W-1:0] data_end;
  logic [IDX_W-1:0] tx_total;
  logic [IDX_W-1:0] rx_total;
  logic             accept;
  logic             tx_fire;
  logic             rx_fire;
  logic             crc_en;
  logic [7:0]       crc_din;
  logic [7:0]       crc_val;
  logic             rx_final;
  logic             crc_bad;

  crf_decode #(
    .NUM_BANKS (NUM_BANKS),
    .MAX_LEN   (MAX_LEN),
    .LEN_W     (LEN_W),
    .DEV_ADDRS (DEV_ADDRS),
    .REG_LAST  (REG_LAST),
    .CRC_BANKS (CRC_BANKS)
  ) u_decode (
    .addr    (req_addr),
    .len     (req_len),
    .is_read (!req_write),
    .dec     (dec)
  );

  crf_crc8 #(
    .POLY (CRC_POLY)
  ) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .en  (crc_en),
    .din (crc_din),
    .crc (crc_val)
  );

  assign accept   = (state == ST_IDLE) && req_valid;
  assign busy     = (state != ST_IDLE);
  assign tx_valid = (state == ST_SEND);
  assign rx_ready = (state == ST_RECV);
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_fire  = rx_ready && rx_valid && !rx_stop;

  // Frame geometry derived from the latched request.
  assign data_end = IDX_W'(q_len) + IDX_W'(2);
  assign tx_total = q_read ? IDX_W'(2) : (data_end + (q_crc ? IDX_W'(2) : IDX_W'(0)));
  assign rx_total = IDX_W'(q_len) + (q_crc ? IDX_W'(1) : IDX_W'(0));
  assign tx_last  = tx_valid && (tx_idx == tx_total - IDX_W'(1));
  assign rx_final = (rx_idx == rx_total - IDX_W'(1));
  assign crc_bad  = q_crc && (rx_idx == IDX_W'(q_len)) && (rx_data != crc_val);

  // Outbound byte selection: address, register, data, CRC, pad.
  always_comb begin
    if (tx_idx == IDX_W'(0)) begin
      tx_data = q_dev;
    end else if (tx_idx == IDX_W'(1)) begin
      tx_data = q_reg;
    end else if (tx_idx < data_end) begin
      tx_data = q_wdata[7:0];
    end else if (tx_idx == data_end) begin
      tx_data = crc_val;
    end else begin
      tx_data = 8'h00;
    end
  end

  // The CRC covers header and data in both directions, never CRC or pad.
  assign crc_en  = (tx_fire && (tx_idx < data_end)) ||
                   (rx_fire && (rx_idx < IDX_W'(q_len)));
  assign crc_din = tx_fire ? tx_data : rx_data;

  always_comb begin
    rx_buf_nx = rx_buf;
    for (int b = 0; b < MAX_LEN; b++) begin
      if ((rx_idx == IDX_W'(b)) && (rx_idx < IDX_W'(q_len))) begin
        rx_buf_nx[b*8 +: 8] = rx_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      q_read    <= 1'b0;
      q_crc     <= 1'b0;
      q_len     <= '0;
      q_wdata   <= '0;
      q_dev     <= '0;
      q_reg     <= '0;
      tx_idx    <= '0;
      rx_idx    <= '0;
      rx_buf    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            q_read  <= !req_write;
            q_crc   <= dec.use_crc;
            q_len   <= req_len;
            q_wdata <= req_wdata;
            q_dev   <= dec.dev_byte;
            q_reg   <= dec.reg_byte;
            tx_idx  <= '0;
            rx_idx  <= '0;
            rx_buf  <= '0;
            if (dec.ok) begin
              state <= ST_SEND;
            end else begin
              state     <= ST_DONE;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end
          end
        end
        ST_SEND: begin
          if (tx_fire) begin
            tx_idx <= tx_idx + IDX_W'(1);
            if ((tx_idx >= IDX_W'(2)) && (tx_idx < data_end)) begin
              q_wdata <= q_wdata >> 8;
            end
            if (tx_last) begin
              if (q_read) begin
                state <= ST_RECV;
              end else begin
                state     <= ST_DONE;
                rsp_done  <= 1'b1;
                rsp_rdata <= '0;
              end
            end
          end
        end
        ST_RECV: begin
          if (rx_stop) begin
            state     <= ST_DONE;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else if (rx_valid) begin
            rx_idx <= rx_idx + IDX_W'(1);
            rx_buf <= rx_buf_nx;
            if (rx_final) begin
              state <= ST_DONE;
              if (crc_bad) begin
                rsp_err   <= 1'b1;
                rsp_rdata <= '0;
              end else begin
                rsp_done  <= 1'b1;
                rsp_rdata <= rx_buf_nx;
              end
            end
          end
        end
        ST_DONE: begin
          rsp_done <= 1'b0;
          rsp_err  <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rsp_done && rsp_err)); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rsp_done || rsp_err) |=> !(rsp_done || rsp_err)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!tx_valid && !rsp_done && !rsp_err)); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0)); // R9
  AST_ILLEGAL_NO_TX: assert property (@(posedge clk) disable iff (rst)
    (accept && !dec.ok) |=> (rsp_err && !tx_valid)); // R3

endmodule

// File: tb/test_crc_reg_framer.sv
module test_crc_reg_framer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        busy;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        rx_stop = 1'b0;
  logic        rsp_done;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int hold_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_reg_framer i_crc_reg_framer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata), .busy(busy),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_stop(rx_stop),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  // Bitwise CRC-8, polynomial 0x07, MSB first.
  function automatic logic [7:0] m_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = r << 1;
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  function automatic logic [6:0] m_dev(input int bank);
    case (bank)
      0: return 7'h4E;
      1: return 7'h1A;
      2: return 7'h64;
      default: return 7'h34;
    endcase
  endfunction

  function automatic logic [7:0] m_last(input int bank);
    case (bank)
      1: return 8'h3B;
      2: return 8'h1C;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // mode: 0 good response, 1 corrupted CRC, 2 response stopped early.
  task automatic do_req(input logic wr, input logic [15:0] addr, input logic [2:0] len,
                        input logic [31:0] wd, input int mode_in, input int stop_raw,
                        input bit hold, input string tag);
    int bank;
    bit legal, crcb;
    int mode;
    logic [7:0] e[16];
    int e_n;
    logic [7:0] resp[8];
    int nresp;
    int stop_at;
    logic [7:0] c;
    logic [31:0] exp_rd;
    bit exp_err;
    logic [7:0] got[16];
    bit lastf[16];
    int got_n, sent, cyc;
    bit stall_prev;
    logic [7:0] stall_data;
    logic stall_last;
    bit frame_ok;
    logic [7:0] bad_a, bad_e;

    bank  = int'(addr[15:8]);
    legal = (bank < 4) && (addr[7:0] <= m_last(bank)) && (len >= 1) && (len <= 4);
    crcb  = (bank == 1) || (bank == 2);
    mode  = mode_in;
    if (mode == 1 && !crcb) mode = 0;

    e_n = 0;
    exp_rd = '0;
    nresp = 0;
    stop_at = -1;
    if (legal) begin
      e[0] = {m_dev(bank), !wr};
      e[1] = crcb ? {2'(len - 3'd1), addr[5:0]} : addr[7:0];
      c = m_crc(8'h00, e[0]);
      c = m_crc(c, e[1]);
      e_n = 2;
      if (wr) begin
        for (int i = 0; i < int'(len); i++) begin
          e[e_n] = wd[8*i +: 8];
          c = m_crc(c, e[e_n]);
          e_n++;
        end
        if (crcb) begin
          e[e_n] = c; e_n++;
          e[e_n] = 8'h00; e_n++;
        end
      end else begin
        for (int i = 0; i < int'(len); i++) begin
          resp[i] = 8'($urandom);
          c = m_crc(c, resp[i]);
          exp_rd[8*i +: 8] = resp[i];
        end
        nresp = int'(len);
        if (crcb) begin
          resp[nresp] = (mode == 1) ? (c ^ 8'h24) : c;
          nresp++;
        end
        if (mode == 2) stop_at = stop_raw % nresp;
      end
    end
    exp_err = !legal || (!wr && mode != 0);
    if (exp_err || wr) exp_rd = '0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len; req_wdata = wd;
    got_n = 0; sent = 0; cyc = 0; stall_prev = 0; stall_data = '0; stall_last = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        if (hold) begin
          req_write = ~wr; req_addr = 16'h0007; req_len = 3'd1;
        end else begin
          req_valid = 1'b0;
        end
        check(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
      end
      if (rsp_done || rsp_err) break;
      if (cyc > 300) begin
        check(1'b0, tag, "transaction timeout", 32'(cyc), 32'd300);
        break;
      end
      if (stall_prev && (!tx_valid || tx_data != stall_data || tx_last != stall_last)) hold_bad++;
      tx_ready = (($urandom % 4) != 0);
      rx_valid = 1'b0;
      rx_stop  = 1'b0;
      if (rx_ready) begin
        if (mode == 2 && sent == stop_at) begin
          rx_stop = 1'b1;
          rx_valid = ($urandom % 2) == 0;
          rx_data  = 8'hEE;
        end else if (sent < nresp && ($urandom % 3) != 0) begin
          rx_valid = 1'b1;
          rx_data  = resp[sent];
        end
      end
      if (tx_valid && tx_ready && got_n < 16) begin
        got[got_n] = tx_data; lastf[got_n] = tx_last; got_n++;
      end
      if (rx_valid && rx_ready && !rx_stop) sent++;
      stall_prev = tx_valid && !tx_ready;
      stall_data = tx_data;
      stall_last = tx_last;
    end
    req_valid = 1'b0;
    rx_valid = 1'b0;
    rx_stop = 1'b0;

    frame_ok = (got_n == e_n);
    bad_a = '0; bad_e = '0;
    for (int i = 0; i < got_n && i < e_n; i++) begin
      if (got[i] != e[i] || lastf[i] != (i == e_n - 1)) begin
        if (frame_ok) begin bad_a = got[i]; bad_e = e[i]; end
        frame_ok = 0;
      end
    end
    check(frame_ok, tag, "frame length/bytes", {bad_a, 8'(got_n), 16'h0}, {bad_e, 8'(e_n), 16'h0});
    check(rsp_err == exp_err && rsp_done == !exp_err, tag, "done/err",
          {30'h0, rsp_done, rsp_err}, {30'h0, !exp_err, exp_err});
    check(rsp_rdata == exp_rd, tag, "rdata", rsp_rdata, exp_rd);
    @(negedge clk);
    check(!busy && !rsp_done && !rsp_err && !tx_valid, "R10", "release after response",
          {28'h0, busy, rsp_done, rsp_err, tx_valid}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !tx_valid && !rx_ready && !rsp_done && !rsp_err, "R1", "reset outputs",
          {27'h0, busy, tx_valid, rx_ready, rsp_done, rsp_err}, 32'h0);

    // R2 device address per bank, both directions
    do_req(1'b0, 16'h0010, 3'd1, 32'h0, 0, 0, 0, "R2");
    do_req(1'b0, 16'h0110, 3'd1, 32'h0, 0, 0, 0, "R2");
    do_req(1'b1, 16'h0210, 3'd1, 32'h5A, 0, 0, 0, "R2");
    do_req(1'b1, 16'h0310, 3'd1, 32'hA5, 0, 0, 0, "R2");
    // R5 plain banks
    do_req(1'b1, 16'h00C7, 3'd4, 32'hA1B2C3D4, 0, 0, 0, "R5");
    do_req(1'b0, 16'h03F0, 3'd3, 32'h0, 0, 0, 0, "R5");
    // R6 length code in register byte at range edges
    do_req(1'b0, 16'h013B, 3'd4, 32'h0, 0, 0, 0, "R6");
    do_req(1'b1, 16'h021C, 3'd2, 32'h0000BEEF, 0, 0, 0, "R6");
    // R7 protected write
    do_req(1'b1, 16'h0105, 3'd1, 32'h3C, 0, 0, 0, "R7");
    do_req(1'b1, 16'h0200, 3'd4, 32'hFFFFFFFF, 0, 0, 0, "R7");
    // R8 protected read good and corrupted
    do_req(1'b0, 16'h0201, 3'd4, 32'h0, 0, 0, 0, "R8");
    do_req(1'b0, 16'h0120, 3'd2, 32'h0, 1, 0, 0, "R8");
    // R9 short reads, including stop before any byte
    do_req(1'b0, 16'h0102, 3'd3, 32'h0, 2, 2, 0, "R9");
    do_req(1'b0, 16'h0044, 3'd4, 32'h0, 2, 0, 0, "R9");
    do_req(1'b0, 16'h0211, 3'd2, 32'h0, 2, 2, 0, "R9");
    // R3 illegal addresses
    do_req(1'b0, 16'h013C, 3'd1, 32'h0, 0, 0, 0, "R3");
    do_req(1'b1, 16'h021D, 3'd1, 32'h0, 0, 0, 0, "R3");
    do_req(1'b0, 16'h0400, 3'd1, 32'h0, 0, 0, 0, "R3");
    do_req(1'b1, 16'hFFFF, 3'd2, 32'h0, 0, 0, 0, "R3");
    // R4 illegal lengths
    do_req(1'b0, 16'h0001, 3'd0, 32'h0, 0, 0, 0, "R4");
    do_req(1'b1, 16'h0101, 3'd5, 32'h0, 0, 0, 0, "R4");
    do_req(1'b0, 16'h0301, 3'd7, 32'h0, 0, 0, 0, "R4");
    // R10 request held during busy is ignored
    do_req(1'b1, 16'h0110, 3'd3, 32'h00123456, 0, 0, 1, "R10");
    do_req(1'b0, 16'h0220, 3'd2, 32'h0, 0, 0, 1, "R10");

    // Random mix
    for (int k = 0; k < 300; k++) begin
      int bsel, mode;
      logic [15:0] a;
      logic [2:0] l;
      logic w;
      string tag;
      bsel = int'($urandom % 5);
      a[15:8] = (bsel == 4) ? 8'(4 + ($urandom % 252)) : 8'(bsel);
      a[7:0]  = (($urandom % 3) == 0) ? 8'(m_last(bsel) + 8'($urandom % 3) - 8'd1) : 8'($urandom);
      l = 3'($urandom % 6);
      w = 1'($urandom);
      mode = int'($urandom % 3);
      if (bsel == 4 || a[7:0] > m_last(bsel)) tag = "R3";
      else if (l == 0 || l > 4) tag = "R4";
      else if (w) tag = (bsel == 1 || bsel == 2) ? "R7" : "R5";
      else if (mode == 2) tag = "R9";
      else tag = (bsel == 1 || bsel == 2) ? "R8" : "R5";
      do_req(w, a, l, $urandom, mode, int'($urandom % 8), 0, tag);
    end

    // R11 back-pressure stability observed across all transactions
    check(hold_bad == 0, "R11", "tx held under stall", 32'(hold_bad), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule